// File: doc/BRIEF.md
# Frequency-Setting Watchdog with Safe-Code Fallback

This block guards a programmable clock-frequency setting against a bad overclocking choice. Software arms it and sets a unit count. The block then counts the units down, each unit being a fixed number of system-clock cycles taken from one of two timebases. A long timebase and a short one are available. Each write to the count register reloads the countdown and acts as the service operation.

If the count runs out, the block latches an alarm and sends out a one-cycle reset request. It also replaces the requested frequency code with a safe code that software stored beforehand. While the alarm is set, the direct-divider source is overridden, so that the safe code is the one that takes effect. The alarm stays set until software clears it.

The clock generator's PLL and the serial bus that writes the registers sit outside this block. The block receives plain one-cycle write strobes. Its outputs are the effective 5-bit frequency code, the source selection, the alarm flag and the reset-request pulse.

Top module: `sfw_top`

## Requirements
- R1: After a synchronous reset the control byte reads 00h, the count reads FFh, the timebase select reads 0, alarm and reset request are low, and the effective code equals `req_code`.
- R2: The control byte has four fields. Bit 7 selects the source (1 = direct divider registers). Bit 6 is the enable (1 = armed). Bit 5 is the alarm status. Bits 4:0 are the safe code. A control write stores bits 7, 6 and 4:0, and `ctrl_rdata` returns them with the live alarm in bit 5.
- R3: When armed with count N, each unit lasts D cycles: D = SLOW_DIV when the timebase select is 0, and D = FAST_DIV when it is 1. The count drops by one at the end of each unit and can be read back. The alarm sets exactly (N+1)·D clock edges after the edge that armed the block.
- R4: With the reset count FFh and the slow timebase, the alarm sets 256·SLOW_DIV edges after the block is armed.
- R5: While the alarm is set, `eff_code` equals the stored safe code and `src_direct` is 0.
- R6: `rst_req` goes high for exactly one cycle, on the same edge that sets the alarm.
- R7: A count write reloads the count and restarts the current unit. Expiry then follows (N+1)·D edges after that write.
- R8: While bit 6 is 0, the count does not change and no alarm is raised.
- R9: The alarm is cleared only by a control write with bit 5 = 0. A write with bit 5 = 1 neither sets nor clears it. After the alarm is cleared, the countdown resumes from the held count.
- R10: While the alarm is set, the count stays frozen unless software writes it.
- R11: Without an alarm, `eff_code` equals `req_code` and `src_direct` equals control bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write data |
| cnt_wr | input | 1 | Count write strobe (reload / service) |
| cnt_wdata | input | 8 | Count value in units |
| tb_wr | input | 1 | Timebase select write strobe |
| tb_wdata | input | 1 | 0 = slow unit, 1 = fast unit |
| req_code | input | 5 | Requested frequency code |
| ctrl_rdata | output | 8 | Control byte readback with live alarm |
| cnt_rdata | output | 8 | Remaining unit count |
| tb_rdata | output | 1 | Timebase select readback |
| eff_code | output | 5 | Effective frequency code |
| src_direct | output | 1 | Direct-divider source selected |
| alarm | output | 1 | Latched alarm flag |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
A prescaler that is off by one cycle moves the expiry edge by N+1 cycles. The bench therefore checks the alarm exactly one edge before and at the predicted edge, for several counts on both timebases. A lost restart after a count write or after a timebase change shows up as an early alarm within one unit. A count that decrements while disarmed or during an alarm shows up directly on `cnt_rdata` at the next edge. A wrong alarm latch shows up on `eff_code` and `src_direct` in the cycle after the strobe that should have changed it.

// File: rtl/sfw_pkg.sv
package sfw_pkg;

    localparam int CODE_W = 5;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              src_direct;
        logic              enable;
        logic [CODE_W-1:0] safe_code;
    } sfw_ctrl_t;

    localparam sfw_ctrl_t CTRL_RESET = '{src_direct: 1'b0, enable: 1'b0, safe_code: '0};

    function automatic sfw_ctrl_t unpack_ctrl(input logic [BYTE_W-1:0] b);
        sfw_ctrl_t c;
        c.src_direct = b[7];
        c.enable     = b[6];
        c.safe_code  = b[CODE_W-1:0];
        return c;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_ctrl(input sfw_ctrl_t c, input logic alarm);
        return {c.src_direct, c.enable, alarm, c.safe_code};
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sfw_tick_gen.sv
module sfw_tick_gen #(
    parameter int SLOW_DIV = 29_000_000,
    parameter int FAST_DIV = 100_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    input  logic fast_sel,
    output logic tick
);
    import sfw_pkg::*;

    localparam int MAX_DIV = max_int(SLOW_DIV, FAST_DIV);
    localparam int PRE_W   = $clog2(MAX_DIV + 1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] last_val;

    generate
        if (SLOW_DIV == FAST_DIV) begin : g_single
            assign last_val = PRE_W'(SLOW_DIV - 1);
            logic unused_sel;
            assign unused_sel = fast_sel;
        end else begin : g_dual
            assign last_val = fast_sel ? PRE_W'(FAST_DIV - 1) : PRE_W'(SLOW_DIV - 1);
        end
    endgenerate

    assign tick = run && !restart && (pre_q == last_val);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            pre_q <= '0;
        end else if (pre_q == last_val) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/sfw_down_counter.sv
module sfw_down_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    assign count  = cnt_q;
    assign expire = tick && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '1;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/sfw_ctrl_regs.sv
module sfw_ctrl_regs
    import sfw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [BYTE_W-1:0] ctrl_wdata,
    input  logic              tb_wr,
    input  logic              tb_wdata,
    input  logic              expire,
    input  logic [CODE_W-1:0] req_code,
    output sfw_ctrl_t         ctrl,
    output logic              alarm,
    output logic              fast_sel,
    output logic              rst_req,
    output logic [CODE_W-1:0] eff_code,
    output logic              src_direct
);
    sfw_ctrl_t ctrl_q;
    logic      alarm_q;
    logic      tb_q;
    logic      req_q;
    logic      clear_req;

    assign clear_req = ctrl_wr && !ctrl_wdata[5];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= CTRL_RESET;
            alarm_q <= 1'b0;
            tb_q    <= 1'b0;
            req_q   <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q <= unpack_ctrl(ctrl_wdata);
            end
            if (tb_wr) begin
                tb_q <= tb_wdata;
            end
            if (expire) begin
                alarm_q <= 1'b1;
            end else if (clear_req) begin
                alarm_q <= 1'b0;
            end
            req_q <= expire;
        end
    end

    assign ctrl       = ctrl_q;
    assign alarm      = alarm_q;
    assign fast_sel   = tb_q;
    assign rst_req    = req_q;
    assign eff_code   = alarm_q ? ctrl_q.safe_code : req_code;
    assign src_direct = ctrl_q.src_direct && !alarm_q;

endmodule

// File: rtl/sfw_top.sv
module sfw_top #(
    parameter int SLOW_DIV = 29_000_000,
    parameter int FAST_DIV = 100_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_wr,
    input  logic [7:0] ctrl_wdata,
    input  logic       cnt_wr,
    input  logic [7:0] cnt_wdata,
    input  logic       tb_wr,
    input  logic       tb_wdata,
    input  logic [4:0] req_code,
    output logic [7:0] ctrl_rdata,
    output logic [7:0] cnt_rdata,
    output logic       tb_rdata,
    output logic [4:0] eff_code,
    output logic       src_direct,
    output logic       alarm,
    output logic       rst_req
);
    import sfw_pkg::*;

    sfw_ctrl_t ctrl;
    logic      fast_sel;
    logic      tick;
    logic      expire;
    logic      run;
    logic      restart;

    assign run     = ctrl.enable && !alarm;
    assign restart = cnt_wr || tb_wr;

    sfw_ctrl_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .tb_wr      (tb_wr),
        .tb_wdata   (tb_wdata),
        .expire     (expire),
        .req_code   (req_code),
        .ctrl       (ctrl),
        .alarm      (alarm),
        .fast_sel   (fast_sel),
        .rst_req    (rst_req),
        .eff_code   (eff_code),
        .src_direct (src_direct)
    );

    sfw_tick_gen #(
        .SLOW_DIV (SLOW_DIV),
        .FAST_DIV (FAST_DIV)
    ) u_tick (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .restart  (restart),
        .fast_sel (fast_sel),
        .tick     (tick)
    );

    sfw_down_counter #(
        .CNT_W (BYTE_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_wr),
        .load_val (cnt_wdata),
        .tick     (tick),
        .count    (cnt_rdata),
        .expire   (expire)
    );

    assign ctrl_rdata = pack_ctrl(ctrl, alarm);
    assign tb_rdata   = fast_sel;

endmodule

// File: rtl/sfw_checker.sv
module sfw_checker (
    input logic       clk,
    input logic       rst,
    input logic       ctrl_wr,
    input logic [7:0] ctrl_wdata,
    input logic       cnt_wr,
    input logic [7:0] ctrl_rdata,
    input logic [7:0] cnt_rdata,
    input logic [4:0] eff_code,
    input logic       src_direct,
    input logic       alarm,
    input logic       rst_req
);
    // R6: the alarm never rises without the reset request
    assert_alarm_with_req_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm) |-> rst_req);

    // R6: the reset request is a single-cycle pulse
    assert_req_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R5: during an alarm the safe code is driven and the direct source is off
    assert_safe_code_R5: assert property (@(posedge clk) disable iff (rst)
        alarm |-> (eff_code == ctrl_rdata[4:0] && !src_direct));

    // R10: the count is frozen while the alarm is held
    assert_frozen_in_alarm_R10: assert property (@(posedge clk) disable iff (rst)
        (alarm && !cnt_wr) |=> $stable(cnt_rdata));

    // R8: the count is frozen while disarmed
    assert_idle_when_off_R8: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_rdata[6] && !cnt_wr) |=> $stable(cnt_rdata));

    // R8: no alarm is raised while disarmed
    assert_no_alarm_when_off_R8: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_rdata[6] && !alarm) |=> !alarm);

    // R9: the alarm falls only after a control write with bit 5 low
    assert_clear_by_write_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(alarm) |-> ($past(ctrl_wr) && !$past(ctrl_wdata[5])));

    // R3: without a reload the count never increases
    assert_count_monotonic_R3: assert property (@(posedge clk) disable iff (rst)
        !cnt_wr |=> (cnt_rdata <= $past(cnt_rdata)));
endmodule

bind sfw_top sfw_checker u_sfw_checker (
    .clk        (clk),
    .rst        (rst),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (ctrl_wdata),
    .cnt_wr     (cnt_wr),
    .ctrl_rdata (ctrl_rdata),
    .cnt_rdata  (cnt_rdata),
    .eff_code   (eff_code),
    .src_direct (src_direct),
    .alarm      (alarm),
    .rst_req    (rst_req)
);

// File: tb/sfw_top_tb_top.sv
`timescale 1ns/1ps
module sfw_top_tb_top;
    localparam int SLOW = 7;
    localparam int FAST = 3;
    localparam logic [4:0] REQ = 5'h12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic       cnt_wr = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic       tb_wr = 1'b0;
    logic       tb_wdata = 1'b0;
    logic [4:0] req_code = REQ;
    logic [7:0] ctrl_rdata;
    logic [7:0] cnt_rdata;
    logic       tb_rdata;
    logic [4:0] eff_code;
    logic       src_direct;
    logic       alarm;
    logic       rst_req;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    sfw_top #(.SLOW_DIV(SLOW), .FAST_DIV(FAST)) dut_i (
        .clk(clk), .rst(rst),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .tb_wr(tb_wr), .tb_wdata(tb_wdata),
        .req_code(req_code),
        .ctrl_rdata(ctrl_rdata), .cnt_rdata(cnt_rdata), .tb_rdata(tb_rdata),
        .eff_code(eff_code), .src_direct(src_direct),
        .alarm(alarm), .rst_req(rst_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(2);
        rst = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        ctrl_wr = 1'b1; ctrl_wdata = v;
        step(1);
        ctrl_wr = 1'b0;
    endtask

    task automatic wr_cnt(input logic [7:0] v);
        cnt_wr = 1'b1; cnt_wdata = v;
        step(1);
        cnt_wr = 1'b0;
    endtask

    task automatic wr_tb(input logic v);
        tb_wr = 1'b1; tb_wdata = v;
        step(1);
        tb_wr = 1'b0;
    endtask

    // alarm expected exactly 'edges' clock edges after the last write
    task automatic expect_expiry(input int edges, input logic [4:0] safe, input string tag);
        step(edges - 1);
        chk({tag, " alarm low one edge early"}, alarm, 0);
        chk("R11 eff_code before expiry", eff_code, REQ);
        step(1);
        chk({tag, " alarm set at expiry"}, alarm, 1);
        chk("R6 rst_req at expiry edge", rst_req, 1);
        chk("R5 eff_code is safe code", eff_code, safe);
        chk("R5 src_direct forced low", src_direct, 0);
        step(1);
        chk("R6 rst_req one cycle", rst_req, 0);
        chk("R9 alarm held", alarm, 1);
    endtask

    initial begin
        #4_000_000;
        fails++; checks++;
        $display("FAIL watchdog R1..all actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        step(1);
        do_reset();
        // R1 reset state
        chk("R1 ctrl reset", ctrl_rdata, 8'h00);
        chk("R1 count reset", cnt_rdata, 8'hFF);
        chk("R1 timebase reset", tb_rdata, 0);
        chk("R1 alarm reset", alarm, 0);
        chk("R1 rst_req reset", rst_req, 0);
        chk("R1 eff_code reset", eff_code, REQ);

        // R2 / R11 layout and readback; R9 bit5=1 does not set alarm
        wr_ctrl(8'h9B);
        chk("R2 ctrl readback", ctrl_rdata, 8'h9B);
        chk("R11 src_direct follows bit7", src_direct, 1);
        chk("R11 eff_code passes req", eff_code, REQ);
        wr_ctrl(8'h20);
        chk("R9 bit5 write does not set alarm", alarm, 0);
        chk("R2 ctrl readback bit5 live", ctrl_rdata, 8'h00);

        // R8 disarmed: nothing counts
        wr_tb(1'b1);
        chk("R2 timebase readback", tb_rdata, 1);
        wr_cnt(8'd1);
        step(40);
        chk("R8 count held when off", cnt_rdata, 1);
        chk("R8 no alarm when off", alarm, 0);

        // R3 sweep over both timebases and several counts
        for (int tb = 0; tb < 2; tb++) begin
            for (int n = 0; n < 6; n++) begin
                int d;
                logic [4:0] safe;
                d = (tb == 1) ? FAST : SLOW;
                safe = 5'(n * 5 + 3);
                do_reset();
                wr_tb(tb[0]);
                wr_cnt(8'(n));
                wr_ctrl({3'b110, safe});
                chk("R11 src_direct while armed", src_direct, 1);
                if (n >= 1) begin
                    step(d);
                    chk("R3 count after one unit", cnt_rdata, n - 1);
                    expect_expiry(n * d, safe, "R3");
                end else begin
                    expect_expiry(d, safe, "R3");
                end
            end
        end

        // R4 default count on slow timebase
        do_reset();
        wr_ctrl(8'h4A);
        expect_expiry(256 * SLOW, 5'h0A, "R4");

        // R7 kick: reload midway restarts the unit
        do_reset();
        wr_tb(1'b1);
        wr_cnt(8'd2);
        wr_ctrl(8'h45);
        step(4);
        chk("R7 count before kick", cnt_rdata, 1);
        wr_cnt(8'd2);
        chk("R7 count reloaded", cnt_rdata, 2);
        expect_expiry(3 * FAST, 5'h05, "R7");

        // R10 frozen during alarm, R9 clear semantics
        step(6);
        chk("R10 count frozen in alarm", cnt_rdata, 0);
        wr_ctrl(8'h65);
        chk("R9 bit5=1 write keeps alarm", alarm, 1);
        wr_ctrl(8'hC5);
        chk("R9 clear with bit5=0", alarm, 0);
        chk("R11 src_direct after clear", src_direct, 1);
        expect_expiry(FAST, 5'h05, "R9");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule